// File: doc/BRIEF.md
# Cache Line Refill Sequencer

After a cache miss, this block fetches one multiword line from the memory behind the cache. It runs on the same clock as that memory bus. A request carries the line address and the index of the word that missed. The sequencer raises `busy_o` and drives the address for one cycle. It then waits out the memory access latency and strobes each word of the line onto its fill outputs as the bus delivers it. When the last word arrives it pulses `done_o`. While `busy_o` is high the requesting pipeline is expected to stall.

A parameter chooses one of three memory organisations, and each has its own timing.

- Narrow memory (MODE 0) has one word per access. It repeats the access latency and one transfer cycle for every word.
- Wide memory (MODE 1) returns the whole line after a single latency, in one transfer cycle.
- Banked memory (MODE 2) starts every bank at once. After one latency the banks send one word per cycle.

With the default line of 4 words and a latency of 15, a refill takes 65, 17 or 20 bus cycles. These counts include the address cycle.

An optional critical-word-first ordering starts the transfers at the word that missed and wraps around the line. An early-restart strobe marks the cycle in which that word is delivered, so the pipeline can resume before the line is complete.

Top module: `refill_seq`

## Requirements
- R1: After reset, `busy_o`, `addr_phase_o`, `done_o` and `early_o` are 0. `fill_valid_o` and `fill_data_o` are all zero.
- R2: When `req_i` is high in an idle cycle, the request is accepted at that clock edge. In the next cycle (cycle 1) `addr_phase_o` is high for exactly one cycle. `addr_o` equals the requested line address throughout the refill.
- R3: In MODE 0, transfer k (k = 0 to WORDS-1) occurs in cycle 1+(k+1)·(LAT+1). The refill lasts 1+WORDS·(LAT+1) cycles.
- R4: In MODE 1, all words are strobed together in cycle LAT+2 (`fill_valid_o` all ones). The refill lasts LAT+2 cycles.
- R5: In MODE 2, transfer k occurs in cycle LAT+2+k. The refill lasts 1+LAT+WORDS cycles.
- R6: `busy_o` is high from cycle 1 through the last transfer cycle, and low after it. `done_o` pulses for one cycle, in the last transfer cycle.
- R7: Bit i of `fill_valid_o` marks word i of the line. With CWF=0, transfer k delivers word k. With CWF=1, transfer k delivers word (crit+k) mod WORDS.
- R8: `early_o` is high only in the cycle that strobes the critical word, which is the request's `crit_i`. In MODE 1 that is the single transfer cycle.
- R9: A request raised while busy is ignored. Address and timing of the refill in progress are unchanged, and no second refill follows.
- R10: Lane i of `fill_data_o` (bits i·DW upward) carries lane i of `mem_line_i` when bit i of `fill_valid_o` is set, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Refill request |
| req_addr_i | input | AW | Line address of the miss |
| crit_i | input | log2(WORDS) | Index of the word that missed |
| mem_line_i | input | WORDS·DW | Memory return lanes, one per word |
| busy_o | output | 1 | Refill in progress |
| addr_phase_o | output | 1 | Address cycle on the memory bus |
| addr_o | output | AW | Line address held for the refill |
| fill_valid_o | output | WORDS | Per-word strobe for this cycle |
| fill_data_o | output | WORDS·DW | Strobed words, zero on idle lanes |
| early_o | output | 1 | Critical word delivered this cycle |
| done_o | output | 1 | Last word of the line delivered |

## Verification
A wrong latency count or a wrong transfer counter shifts a strobe or `done_o` by at least one cycle. The cycle-by-cycle comparison catches that in the first cycle the output differs. A wrong critical-index latch or a wrong rotation shows up in the first transfer cycle as the wrong `fill_valid_o` bit or a misplaced `early_o`. A request that is not properly ignored while busy changes `addr_o` in the next cycle, or keeps `busy_o` high past the expected end.

// File: rtl/refill_seq.sv
module refill_seq #(
  parameter int WORDS = 4,
  parameter int LAT   = 15,
  parameter int DW    = 32,
  parameter int AW    = 28,
  parameter int MODE  = 0,
  parameter int CWF   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [AW-1:0]              req_addr_i,
  input  logic [$clog2(WORDS)-1:0]   crit_i,
  input  logic [WORDS*DW-1:0]        mem_line_i,
  output logic                       busy_o,
  output logic                       addr_phase_o,
  output logic [AW-1:0]              addr_o,
  output logic [WORDS-1:0]           fill_valid_o,
  output logic [WORDS*DW-1:0]        fill_data_o,
  output logic                       early_o,
  output logic                       done_o
);
  localparam int IW = $clog2(WORDS);
  localparam int CW = $clog2(LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WAIT, S_XFER} state_t;
  state_t         st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  k, crit_q, idx;
  logic [IW:0]    sum;
  logic           xfer, last;

  assign sum  = {1'b0, crit_q} + {1'b0, k};
  assign idx  = (CWF != 0) ? ((sum >= (IW+1)'(WORDS)) ? IW'(sum - (IW+1)'(WORDS)) : IW'(sum)) : k;
  assign xfer = (st == S_XFER);
  assign last = (MODE == 1) || (k == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      k      <= '0;
      crit_q <= '0;
      addr_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_i) begin
          st     <= S_ADDR;
          addr_o <= req_addr_i;
          crit_q <= crit_i;
          k      <= '0;
        end
        S_ADDR: begin
          st  <= S_WAIT;
          cnt <= CW'(LAT - 1);
        end
        S_WAIT: if (cnt == '0) st <= S_XFER;
                else cnt <= cnt - 1'b1;
        default: begin
          if (last) st <= S_IDLE;
          else begin
            k <= k + 1'b1;
            if (MODE == 0) begin
              st  <= S_WAIT;
              cnt <= CW'(LAT - 1);
            end
          end
        end
      endcase
    end
  end

  assign busy_o       = (st != S_IDLE);
  assign addr_phase_o = (st == S_ADDR);
  assign done_o       = xfer && last;
  assign early_o      = xfer && ((MODE == 1) || (idx == crit_q));
  assign fill_valid_o = !xfer ? '0 : (MODE == 1) ? '1 : (WORDS'(1) << idx);

  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    assign fill_data_o[i*DW +: DW] = fill_valid_o[i] ? mem_line_i[i*DW +: DW] : '0;
  end

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> addr_phase_o);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !addr_phase_o) |-> $stable(addr_o));
  assert_latency_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase_o |=> (fill_valid_o == '0));
  assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  assert_early_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    early_o |-> (fill_valid_o != '0));
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && req_i) |=> busy_o);
endmodule

// File: tb/refill_seq_bench.sv
module refill_seq_bench;
  localparam int CLK_NS = 10;
  localparam int W  = 4;
  localparam int L  = 15;
  localparam int DW = 32;
  localparam int AW = 28;

  logic clk = 0, rst_n = 0, req = 0;
  logic [AW-1:0]   addr = '0;
  logic [1:0]      crit = '0;
  logic [W*DW-1:0] mem = '0;

  logic            busy_a  [3][2];
  logic            aph_a   [3][2];
  logic [AW-1:0]   addr_a  [3][2];
  logic [W-1:0]    fv_a    [3][2];
  logic [W*DW-1:0] fd_a    [3][2];
  logic            early_a [3][2];
  logic            done_a  [3][2];

  int vectors = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  for (genvar gm = 0; gm < 3; gm++) begin : g_mode
    for (genvar gc = 0; gc < 2; gc++) begin : g_cwf
      refill_seq #(.WORDS(W), .LAT(L), .DW(DW), .AW(AW), .MODE(gm), .CWF(gc)) u_refill_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(addr), .crit_i(crit),
        .mem_line_i(mem), .busy_o(busy_a[gm][gc]), .addr_phase_o(aph_a[gm][gc]),
        .addr_o(addr_a[gm][gc]), .fill_valid_o(fv_a[gm][gc]), .fill_data_o(fd_a[gm][gc]),
        .early_o(early_a[gm][gc]), .done_o(done_a[gm][gc]));
    end
  end

  task automatic chk(input string rq, input logic [W*DW-1:0] act, input logic [W*DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int total(input int m);
    return (m == 0) ? 1 + W*(L+1) : (m == 1) ? L + 2 : 1 + L + W;
  endfunction

  task automatic check_cycle(input int t, input logic [AW-1:0] a, input int cr);
    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c < 2; c++) begin
        int n = total(m);
        logic [W-1:0] msk = '0;
        logic ex_early = 0;
        logic [W*DW-1:0] dat = '0;
        for (int k = 0; k < W; k++) begin
          int tk = (m == 0) ? 1 + (k+1)*(L+1) : (m == 1) ? L + 2 : L + 2 + k;
          int ix = (c == 1 && m != 1) ? (cr + k) % W : k;
          if (t == tk) begin
            msk[ix] = 1'b1;
            if (ix == cr) ex_early = 1'b1;
          end
        end
        for (int i = 0; i < W; i++)
          if (msk[i]) dat[i*DW +: DW] = mem[i*DW +: DW];
        chk(m == 0 ? "R6 busy (R3 narrow)" : m == 1 ? "R6 busy (R4 wide)" : "R6 busy (R5 banked)",
            W*DW'(busy_a[m][c]), W*DW'(t <= n));
        chk("R2 addr phase", W*DW'(aph_a[m][c]), W*DW'(t == 1));
        if (t <= n) chk("R2/R9 addr hold", W*DW'(addr_a[m][c]), W*DW'(a));
        chk("R6 done pulse", W*DW'(done_a[m][c]), W*DW'(t == n));
        chk(m == 0 ? "R3/R7 strobe" : m == 1 ? "R4/R7 strobe" : "R5/R7 strobe",
            W*DW'(fv_a[m][c]), W*DW'(msk));
        chk("R8 early restart", W*DW'(early_a[m][c]), W*DW'(ex_early));
        chk("R10 fill data", fd_a[m][c], dat);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 2; c++) begin
        chk("R1 reset busy", W*DW'(busy_a[m][c] | aph_a[m][c] | done_a[m][c] | early_a[m][c]), '0);
        chk("R1 reset strobe", W*DW'(fv_a[m][c]), '0);
        chk("R1 reset data", fd_a[m][c], '0);
      end
    rst_n = 1;
    @(negedge clk);
    for (int cr = 0; cr < W; cr++) begin
      for (int pk = 0; pk < 2; pk++) begin
        logic [AW-1:0] a = AW'(28'h0A5_0000 + cr*16 + pk*3);
        mem  = {32'hDD00_0003, 32'hCC00_0002, 32'hBB00_0001, 32'hAA00_0000} + W*DW'(cr*7 + pk);
        req  = 1; addr = a; crit = 2'(cr);
        @(negedge clk);
        req = 0;
        for (int t = 1; t <= total(0) + 2; t++) begin
          check_cycle(t, a, cr);
          if (pk == 1 && t == 5) begin
            req = 1; addr = ~a; crit = 2'(cr + 1);   // R9: request while busy
          end else if (t == 6) begin
            req = 0;
          end
          @(negedge clk);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule